// File: doc/BRIEF.md
# Section Transmit Framer with Frame-Synchronous Scrambler

This block turns a terminal-side stream of bytes or nibbles into a serial line signal that follows a 9-row by 270-column frame. The first nine columns of each row carry overhead. In the first row the block writes three framing bytes of the first pattern and three of the second into the leading six columns. In the second row it writes the bit-interleaved parity of the previous frame into the first column. It then scrambles the frame in step with the frame and shifts it out MSB first. All logic runs on one clock, which is the bit clock recovered by the receiver. The transmitted line therefore stays loop-timed to the network and needs no local reference.

The terminal offers words on a valid/ready interface. Ready is a fixed time slot in the bit schedule and does not depend on valid. In byte mode it is high one cycle in eight. In nibble mode it is high two cycles in eight. The terminal may hold valid high for as long as it likes, and a word moves only in a cycle where both are high. If no word moves in a slot, the block sends zero bits in that position, and the frame position still advances. A sync flag on an accepted word moves the frame origin to that word. Scrambling and parity insertion are enabled separately. A loopback control sends the transmitted bit into the local receive path, and the line output keeps running.

Top module: `sts_tx_framer`

## Requirements
- R1: Out of reset, tx_ser, frame_start and t_ready are 0. The first word slot after reset carries frame position row 0, column 0.
- R2: A frame is 9 x 270 = 2430 byte positions. Without a sync, the position wraps after the last one. frame_start is a single-cycle pulse in the cycle that puts the first bit of position (row 0, column 0) on tx_ser. Consecutive pulses are 19440 cycles apart.
- R3: In row 0, columns 0..2 are sent as 8'hF6 and columns 3..5 as 8'h28, replacing terminal data. Columns 0..8 of row 0 always leave unscrambled, and columns 6..8 carry terminal data.
- R4: t_ready is high when the bit phase counter (0 after reset, +1 per cycle, mod 8) is 7. In nibble mode (nib_mode=1) it is also high at phase 3. In nibble mode, t_data[3:0] holds the high nibble in the phase-3 slot and the low nibble in the phase-7 slot. A half or byte not accepted in its slot is sent as zeros.
- R5: An accepted word with t_sync=1 becomes row 0, column 0. In nibble mode only the high-nibble slot carries the sync.
- R6: When scr_en=1, every byte outside row 0 columns 0..8 is XORed, MSB first, with the output of a 7-bit generator 1+x^6+x^7. The generator emits state bit 6 and shifts in bit6^bit5. It is loaded with all ones at row 0 column 9 and steps 8 times per byte, whatever scr_en is. When scr_en=0, data passes unchanged.
- R7: When b1_en=1, row 1 column 0 is replaced, before scrambling, by the XOR of all line bytes (as sent) of the previous frame. A frame runs from a row-0/column-0 byte to the byte before the next one. The first frame after reset uses 8'h00. When b1_en=0, the terminal byte passes at that position.
- R8: The byte taken at phase 7 leaves MSB first on tx_ser, one bit per cycle, over the next 8 cycles (phases 0..7).
- R9: rx_local equals tx_ser when loop_en=1 and line_rx when loop_en=0. tx_ser is the same in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_mode | input | 1 | 1: nibble intake, 0: byte intake |
| scr_en | input | 1 | Scrambling enable |
| b1_en | input | 1 | Parity byte insertion enable |
| loop_en | input | 1 | Terminal loopback enable |
| t_data | input | 8 | Terminal byte, or nibble in bits 3..0 |
| t_valid | input | 1 | Terminal word valid |
| t_sync | input | 1 | Accepted word is frame origin |
| t_ready | output | 1 | Intake slot open |
| line_rx | input | 1 | Serial data from the line receiver |
| tx_ser | output | 1 | Serial line output |
| frame_start | output | 1 | First bit of a frame on tx_ser |
| rx_local | output | 1 | Serial data into the local receive path |

## Verification
The assertions check the bit-phase slot schedule of t_ready on every cycle. They also check that frame_start is a single-cycle pulse with the full frame period whenever no sync has moved the origin, and that the eight bits after each pulse spell the first framing byte. Whether the scrambler is reseeded at the right column, whether parity covers exactly the bytes of the previous, possibly shortened frame, how nibbles are assembled, and whether zero filler is sent for unused slots all show only in the bench's scenarios. There, a scoreboard predicts every line byte through frame wraps, mid-frame syncs, mode changes and loopback.

// File: rtl/sts_tx_pkg.sv
package sts_tx_pkg;
  localparam logic [7:0] FRM_PAT_A  = 8'hF6;
  localparam logic [7:0] FRM_PAT_B  = 8'h28;
  localparam logic [6:0] SCR_SEED   = 7'h7F;
  localparam int         BYTE_BITS  = 8;
endpackage

// File: rtl/sts_tx_pos.sv
module sts_tx_pos #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          realign,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  logic [RW-1:0] nxt_row;
  logic [CW-1:0] nxt_col;

  always_comb begin
    row = realign ? '0 : nxt_row;
    col = realign ? '0 : nxt_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_row <= '0;
      nxt_col <= '0;
    end else if (step) begin
      if (col == CW'(COLS - 1)) begin
        nxt_col <= '0;
        nxt_row <= (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
      end else begin
        nxt_col <= col + CW'(1);
        nxt_row <= row;
      end
    end
  end
endmodule

// File: rtl/sts_tx_scr.sv
module sts_tx_scr
  import sts_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       reseed,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [6:0] st, st_nxt, walk;

  always_comb begin
    walk = st;
    dout = din;
    for (int i = BYTE_BITS - 1; i >= 0; i--) begin
      dout[i] = din[i] ^ (en & walk[6]);
      walk    = {walk[5:0], walk[6] ^ walk[5]};
    end
    st_nxt = walk;
    if (reseed) begin
      dout   = din;
      st_nxt = SCR_SEED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= SCR_SEED;
    else if (step) st <= st_nxt;
  end
endmodule

// File: rtl/sts_tx_bip.sv
module sts_tx_bip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       first,
  input  logic [7:0] din,
  output logic [7:0] par
);
  logic [7:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      par <= '0;
    end else if (step) begin
      if (first) begin
        par <= acc;
        acc <= din;
      end else begin
        acc <= acc ^ din;
      end
    end
  end
endmodule

// File: rtl/sts_tx_framer.sv
module sts_tx_framer
  import sts_tx_pkg::*;
#(
  parameter int ROWS  = 9,
  parameter int COLS  = 270,
  parameter int STS_N = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_mode,
  input  logic       scr_en,
  input  logic       b1_en,
  input  logic       loop_en,
  input  logic [7:0] t_data,
  input  logic       t_valid,
  input  logic       t_sync,
  output logic       t_ready,
  input  logic       line_rx,
  output logic       tx_ser,
  output logic       frame_start,
  output logic       rx_local
);
  localparam int RW       = $clog2(ROWS);
  localparam int CW       = $clog2(COLS);
  localparam int SOH_COLS = 3 * STS_N;

  logic [2:0]    bcnt;
  logic          load, take;
  logic [3:0]    hi_nib;
  logic          hi_sync;
  logic [7:0]    in_byte, ins_byte, line_byte, sreg, parity;
  logic          in_sync, first, unscr;
  logic          fs_q;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  // fixed intake schedule driven by the bit phase
  assign load    = (bcnt == 3'd7);
  assign t_ready = load | (nib_mode & (bcnt == 3'd3));
  assign take    = t_ready & t_valid;

  always_comb begin
    if (nib_mode) begin
      in_byte = {hi_nib, take ? t_data[3:0] : 4'h0};
      in_sync = hi_sync;
    end else begin
      in_byte = take ? t_data : 8'h00;
      in_sync = take & t_sync;
    end
  end

  sts_tx_pos #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(load), .realign(in_sync),
    .row(row), .col(col)
  );

  assign first = (row == '0) && (col == '0);
  assign unscr = (row == '0) && (col < CW'(SOH_COLS));

  // overhead insertion ahead of the scrambler
  always_comb begin
    ins_byte = in_byte;
    if (row == '0 && col < CW'(STS_N))
      ins_byte = FRM_PAT_A;
    else if (row == '0 && col < CW'(2 * STS_N))
      ins_byte = FRM_PAT_B;
    else if (b1_en && row == RW'(1) && col == '0)
      ins_byte = parity;
  end

  sts_tx_scr u_scr (
    .clk(clk), .rst_n(rst_n), .step(load), .reseed(unscr),
    .en(scr_en), .din(ins_byte), .dout(line_byte)
  );

  sts_tx_bip u_bip (
    .clk(clk), .rst_n(rst_n), .step(load), .first(first),
    .din(line_byte), .par(parity)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= '0;
      sreg    <= '0;
      fs_q    <= 1'b0;
      hi_nib  <= '0;
      hi_sync <= 1'b0;
    end else begin
      bcnt <= bcnt + 3'd1;
      sreg <= load ? line_byte : {sreg[6:0], 1'b0};
      fs_q <= load & first;
      if (nib_mode && bcnt == 3'd3) begin
        hi_nib  <= take ? t_data[3:0] : 4'h0;
        hi_sync <= take & t_sync;
      end
    end
  end

  assign tx_ser      = sreg[7];
  assign frame_start = fs_q;
  assign rx_local    = loop_en ? tx_ser : line_rx;
endmodule

// File: rtl/sts_tx_chk.sv
module sts_tx_chk #(
  parameter int ROWS = 9,
  parameter int COLS = 270
) (
  input logic clk,
  input logic rst_n,
  input logic nib_mode,
  input logic t_valid,
  input logic t_ready,
  input logic t_sync,
  input logic tx_ser,
  input logic frame_start
);
  localparam int FRAME_BITS = 8 * ROWS * COLS;

  logic [2:0]  ph;
  logic [31:0] gap;
  logic        seen_fs, sync_seen;
  logic [3:0]  cap_cnt;
  logic [7:0]  cap_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      gap       <= '0;
      seen_fs   <= 1'b0;
      sync_seen <= 1'b0;
      cap_cnt   <= '0;
      cap_sh    <= '0;
    end else begin
      ph <= ph + 3'd1;
      if (frame_start) begin
        gap       <= '0;
        seen_fs   <= 1'b1;
        sync_seen <= t_ready & t_valid & t_sync;
      end else begin
        gap <= gap + 32'd1;
        if (t_ready && t_valid && t_sync) sync_seen <= 1'b1;
      end
      if (frame_start) begin
        cap_cnt <= 4'd1;
        cap_sh  <= {7'b0, tx_ser};
      end else if (cap_cnt != 4'd0 && cap_cnt < 4'd8) begin
        cap_cnt <= cap_cnt + 4'd1;
        cap_sh  <= {cap_sh[6:0], tx_ser};
      end else begin
        cap_cnt <= '0;
      end
    end
  end

  AST_READY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    t_ready |-> (ph == 3'd7 || (nib_mode && ph == 3'd3))); // R4
  AST_READY_BYTE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd7) |-> t_ready); // R4
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R2
  AST_FS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && seen_fs && !sync_seen) |-> gap == 32'(FRAME_BITS - 1)); // R2
  AST_FIRST_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_cnt == 4'd8) |-> cap_sh == 8'hF6); // R3
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({tx_ser, frame_start, t_ready})); // R8
endmodule

bind sts_tx_framer sts_tx_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .t_valid(t_valid),
  .t_ready(t_ready), .t_sync(t_sync), .tx_ser(tx_ser), .frame_start(frame_start)
);

// File: tb/tb_sts_tx_framer.sv
module tb_sts_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nib_mode = 1'b0, scr_en = 1'b0, b1_en = 1'b0, loop_en = 1'b0;
  logic [7:0] t_data = '0;
  logic t_valid = 1'b0, t_sync = 1'b0, line_rx = 1'b0;
  logic t_ready, tx_ser, frame_start, rx_local;

  always #4 clk = ~clk;

  sts_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .scr_en(scr_en),
    .b1_en(b1_en), .loop_en(loop_en), .t_data(t_data), .t_valid(t_valid),
    .t_sync(t_sync), .t_ready(t_ready), .line_rx(line_rx), .tx_ser(tx_ser),
    .frame_start(frame_start), .rx_local(rx_local)
  );

  typedef struct { logic [7:0] b; logic fs; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  string cur_tag = "R8";
  bit done = 0;

  // reference state
  int m_row = 0, m_col = 0;
  logic [6:0] m_lfsr = 7'h7F;
  logic [7:0] m_acc = '0, m_hold = '0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic [7:0] d, input logic s, output logic [7:0] lb,
                       output logic fs, output string tg);
    logic [7:0] ins;
    if (s) begin m_row = 0; m_col = 0; end
    fs  = (m_row == 0 && m_col == 0);
    tg  = fs ? "R2" : (m_row == 0 && m_col < 6) ? "R3" :
          (m_row == 1 && m_col == 0) ? "R7" : cur_tag;
    ins = d;
    if (m_row == 0 && m_col < 3) ins = 8'hF6;
    else if (m_row == 0 && m_col < 6) ins = 8'h28;
    else if (m_row == 1 && m_col == 0 && b1_en) ins = m_hold;
    if (m_row == 0 && m_col < 9) begin
      lb = ins;
      m_lfsr = 7'h7F;
    end else begin
      for (int i = 7; i >= 0; i--) begin
        lb[i]  = ins[i] ^ (scr_en & m_lfsr[6]);
        m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      end
    end
    if (fs) begin m_hold = m_acc; m_acc = lb; end
    else m_acc = m_acc ^ lb;
    if (m_col == 269) begin
      m_col = 0;
      m_row = (m_row == 8) ? 0 : m_row + 1;
    end else m_col++;
  endtask

  task automatic wait_slot();
    do @(negedge clk); while (t_ready !== 1'b1);
  endtask

  // driver: one byte position per call, pushes the predicted line byte
  task automatic xfer(input logic [7:0] d, input logic v, input logic s);
    logic [7:0] lb;
    logic fs;
    string tg;
    if (nib_mode) begin
      wait_slot(); t_valid = v; t_data = {4'h0, d[7:4]}; t_sync = s;
      @(posedge clk); #1; t_valid = 1'b0; t_sync = 1'b0;
      wait_slot(); t_valid = v; t_data = {4'h0, d[3:0]};
      @(posedge clk); #1; t_valid = 1'b0;
    end else begin
      wait_slot(); t_valid = v; t_data = d; t_sync = s;
      @(posedge clk); #1; t_valid = 1'b0; t_sync = 1'b0;
    end
    model(v ? d : 8'h00, v & s, lb, fs, tg);
    q.push_back('{lb, fs, tg});
  endtask

  task automatic run_bytes(input int n, input int sync_at, input int seed);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = ((i % 97) != 50) || (i == sync_at);
      xfer(8'(i * 37 + seed), v, i == sync_at);
    end
  endtask

  // monitor: pops expected bytes and compares the serial line
  initial begin
    forever begin
      exp_t e;
      logic [7:0] act;
      logic fsa;
      wait (q.size() != 0);
      e = q.pop_front();
      act = '0;
      fsa = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (k == 0) fsa = frame_start;
        else if (frame_start) fsa = 1'b1 ^ e.fs;
        act = {act[6:0], tx_ser};
      end
      check(act == e.b, e.tag, act, e.b);
      check(fsa == e.fs, "R2", {7'b0, fsa}, {7'b0, e.fs});
    end
  end

  task automatic loop_checks();
    repeat (20) begin
      @(negedge clk); loop_en = 1'b0; line_rx = ~line_rx; #1;
      check(rx_local == line_rx, "R9", {7'b0, rx_local}, {7'b0, line_rx});
    end
    repeat (20) begin
      @(negedge clk); loop_en = 1'b1; line_rx = ~tx_ser; #1;
      check(rx_local == tx_ser, "R9", {7'b0, rx_local}, {7'b0, tx_ser});
    end
    @(negedge clk); loop_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs before the first slot
    check(tx_ser == 1'b0, "R1", {7'b0, tx_ser}, 8'h00);
    check(frame_start == 1'b0, "R1", {7'b0, frame_start}, 8'h00);
    check(t_ready == 1'b0, "R1", {7'b0, t_ready}, 8'h00);
    // R1 / R8: free-running from reset origin, past one wrap
    cur_tag = "R1";
    run_bytes(4, -1, 3);
    cur_tag = "R8";
    run_bytes(2430, -1, 11);
    // R6 with loopback toggling alongside (R9)
    scr_en = 1'b1;
    cur_tag = "R6";
    fork
      run_bytes(600, 0, 5);
      loop_checks();
    join
    // R7: parity over a shortened frame, then a full one
    b1_en = 1'b1;
    cur_tag = "R7";
    run_bytes(2430 + 300, 0, 77);
    // R4 / R5: nibble intake with a mid-frame resync
    nib_mode = 1'b1;
    cur_tag = "R4";
    run_bytes(700, 350, 19);
    nib_mode = 1'b0;
    cur_tag = "R5";
    run_bytes(40, 20, 200);
    // R7: parity slot passes terminal data when disabled
    b1_en = 1'b0;
    cur_tag = "R7";
    run_bytes(280, 0, 91);
    wait (q.size() == 0);
    repeat (10) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule